// File: doc/BRIEF.md
# Memory-to-Stream DMA Read Channel

This block is a single-command read engine. It moves a run of 32-bit words from memory onto a valid/ready output stream. A controller loads a word-aligned byte address and a word count on the command port and pulses start. The engine then issues AXI3 read bursts on a 32-bit read master and collects the returned beats in a 128-word buffer. It drains the buffer to the stream and marks the final word with a last flag.

Bursts are cut to a 16-beat maximum. In incrementing mode a burst is also cut short where it would run past a 4 KB page. A keyhole mode instead reads every burst from the one start address. A burst is only launched when the buffer can hold all of it together with every beat already on its way. The number of bursts in flight is capped by a configuration input. An optional swap reverses the byte order of each word. A stall timer flags an error when the channel stops making progress.

Top module: `dma_rd_chan`

## Requirements
- R1: A start pulse is taken only while `busy` is low and `cmd_words` is non-zero. Taking it raises `busy` and clears `done` and `timeout_err` at the next clock edge. A start pulse while busy, or with a zero count, changes nothing.
- R2: After an accepted command, the stream delivers exactly `cmd_words` words in ascending order. In incrementing mode, word i is the memory word at byte address start + 4*i. Once `st_valid` is high it stays high, with `st_data` and `st_last` unchanged, until `st_ready`. `st_last` is high only on the final word.
- R3: With `cmd_fixed` = 1, every burst uses `ar_burst` = 2'b00 and the start address, and each beat returns the word at that address. With `cmd_fixed` = 0, `ar_burst` = 2'b01 and each burst starts where the previous one ended.
- R4: Every burst has `ar_size` = 3'b010 (4 bytes) and at most 16 beats (`ar_len` + 1). No incrementing burst crosses a 4096-byte aligned boundary.
- R5: A burst is requested only when the words buffered plus the beats still owed by earlier bursts plus the new burst's beats total at most 128.
- R6: The number of bursts whose last beat has not yet returned never exceeds the effective cap. The effective cap is `cfg_max_out`, with 0 read as 1 and any value above 9 read as 9.
- R7: Every read request drives `ar_prot` = 3'b000, so `ar_prot[1]` = 0 (secure), and `ar_id` is always 0.
- R8: With `cmd_swap` = 1, each stream word is the returned word with its four bytes in reverse order (bits 7:0 move to 31:24, and so on).
- R9: `done` rises, and `busy` falls, on the clock edge at which the final word is accepted. `done` then stays high until the next accepted start.
- R10: While busy, `timeout_err` is set after `cfg_timeout` consecutive cycles with no progress. Progress means any of: a request handshake, a returned beat, or a stream transfer. A value of 0 turns the timer off. The flag does not stop the transfer.
- R11: Once `ar_valid` is high, it stays high with an unchanged address, length and burst type until `ar_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse |
| cmd_addr | input | 32 | Word-aligned byte start address |
| cmd_words | input | LEN_W | Transfer length in 32-bit words |
| cmd_fixed | input | 1 | 1 = keyhole bursts, 0 = incrementing |
| cmd_swap | input | 1 | Reverse byte order of each word |
| cfg_max_out | input | 4 | Cap on bursts in flight (clamped to 1..9) |
| cfg_timeout | input | TO_W | Stall limit in cycles, 0 = off |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last word accepted (sticky) |
| timeout_err | output | 1 | Stall limit reached (sticky) |
| ar_id | output | ID_W | Read request ID, constant 0 |
| ar_addr | output | 32 | Burst start byte address |
| ar_len | output | 4 | Beats minus one |
| ar_size | output | 3 | Beat size code |
| ar_burst | output | 2 | Burst type |
| ar_prot | output | 3 | Protection attributes |
| ar_valid | output | 1 | Request valid |
| ar_ready | input | 1 | Request accepted |
| r_data | input | 32 | Returned word |
| r_last | input | 1 | Final beat of a burst |
| r_valid | input | 1 | Returned beat valid |
| r_ready | output | 1 | Beat accept, always high |
| st_data | output | 32 | Stream word |
| st_valid | output | 1 | Stream word valid |
| st_last | output | 1 | Final word of the command |
| st_ready | input | 1 | Stream sink ready |

## Verification
Directed transfers each target one aspect of the engine:
- A start two words below a page edge shows whether bursts are cut at the boundary and resume with the correct address.
- A keyhole transfer with swapping shows whether the address is reused and the byte order reversed.
- Holding the sink off during a long transfer shows whether the buffer reservation stops requests at exactly 128 words and whether the stall timer fires.

Randomized transfers vary address, length, mode, cap and the handshake rates on all three channels. Reordering, lost beats, or an over-issued cap then show up as a data mismatch, a wrong word count or a request-time violation. Start pulses while busy and with a zero count show whether a command that should be dropped leaks into the request stream.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;

    localparam int WORD_W    = 32;
    localparam int BURST_MAX = 16;
    localparam int OUT_LIMIT = 9;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01
    } burst_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  len;
        burst_e      kind;
    } ar_req_t;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [3:0] clamp_out(input logic [3:0] m);
        if (m == 4'd0)
            return 4'd1;
        if (m > 4'(OUT_LIMIT))
            return 4'(OUT_LIMIT);
        return m;
    endfunction

    // words left before the next 4 KB page edge, from the word offset in the page
    function automatic logic [10:0] words_to_page(input logic [9:0] word_off);
        return 11'd1024 - {1'b0, word_off};
    endfunction

endpackage

// File: rtl/dma_rd_fifo.sv
module dma_rd_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic          not_empty,
    output logic [CW-1:0] count
);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push)
            store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= wr_ptr + AW'(1);
            if (pop)
                rd_ptr <= rd_ptr + AW'(1);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_data = store[rd_ptr];
    assign not_empty = (count != '0);

endmodule

// File: rtl/dma_rd_burst.sv
module dma_rd_burst
    import dma_rd_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [31:0]      base_addr,
    input  logic [LEN_W-1:0] total_words,
    input  logic             fixed,
    input  logic [3:0]       max_out,
    input  logic [CW-1:0]    fifo_count,
    input  logic             beat,
    input  logic             beat_last,
    input  logic             ar_ready,
    output ar_req_t          req,
    output logic             ar_valid
);

    logic [31:0]      cur_addr;
    logic [LEN_W-1:0] left;
    logic             fixed_q;
    logic [3:0]       in_flight;
    logic [CW-1:0]    owed;

    logic [10:0] limit;
    logic [4:0]  blen;
    logic        room, issue;

    always_comb begin
        limit = 11'(BURST_MAX);
        if (!fixed_q && words_to_page(cur_addr[11:2]) < limit)
            limit = words_to_page(cur_addr[11:2]);
        if (32'(left) < 32'(limit))
            limit = 11'(left);
        blen  = limit[4:0];
        room  = (32'(fifo_count) + 32'(owed) + 32'(blen)) <= 32'(DEPTH);
        issue = !ar_valid && (left != '0) && (in_flight < clamp_out(max_out)) && room;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            left      <= '0;
            fixed_q   <= 1'b0;
            in_flight <= '0;
            owed      <= '0;
            ar_valid  <= 1'b0;
            req       <= '{addr: '0, len: '0, kind: BURST_INCR};
        end else begin
            if (ar_valid && ar_ready)
                ar_valid <= 1'b0;
            if (load) begin
                cur_addr <= base_addr;
                left     <= total_words;
                fixed_q  <= fixed;
            end else if (issue) begin
                ar_valid <= 1'b1;
                req.addr <= cur_addr;
                req.len  <= 4'(blen - 5'd1);
                req.kind <= fixed_q ? BURST_FIXED : BURST_INCR;
                left     <= left - LEN_W'(blen);
                if (!fixed_q)
                    cur_addr <= cur_addr + 32'({blen, 2'b00});
            end
            in_flight <= in_flight + 4'(issue) - 4'(beat && beat_last);
            owed      <= owed + (issue ? CW'(blen) : CW'(0)) - CW'(beat);
        end
    end

endmodule

// File: rtl/dma_rd_chan.sv
module dma_rd_chan
    import dma_rd_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int DEPTH = 128,
    parameter int TO_W  = 16,
    parameter int ID_W  = 4,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic [31:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_words,
    input  logic             cmd_fixed,
    input  logic             cmd_swap,
    input  logic [3:0]       cfg_max_out,
    input  logic [TO_W-1:0]  cfg_timeout,
    output logic             busy,
    output logic             done,
    output logic             timeout_err,
    output logic [ID_W-1:0]  ar_id,
    output logic [31:0]      ar_addr,
    output logic [3:0]       ar_len,
    output logic [2:0]       ar_size,
    output logic [1:0]       ar_burst,
    output logic [2:0]       ar_prot,
    output logic             ar_valid,
    input  logic             ar_ready,
    input  logic [31:0]      r_data,
    input  logic             r_last,
    input  logic             r_valid,
    output logic             r_ready,
    output logic [31:0]      st_data,
    output logic             st_valid,
    output logic             st_last,
    input  logic             st_ready
);

    logic             accept, pop, beat, progress;
    logic             swap_q;
    logic [LEN_W-1:0] out_left;
    logic [TO_W-1:0]  stall_cnt;
    logic [CW-1:0]    fifo_count;
    logic [31:0]      push_word;
    ar_req_t          req;

    assign accept    = cmd_start && !busy && (cmd_words != '0);
    assign beat      = r_valid && r_ready;
    assign pop       = st_valid && st_ready;
    assign progress  = (ar_valid && ar_ready) || beat || pop;
    assign r_ready   = 1'b1;
    assign push_word = swap_q ? swap_bytes(r_data) : r_data;

    dma_rd_burst #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_burst (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .base_addr   (cmd_addr),
        .total_words (cmd_words),
        .fixed       (cmd_fixed),
        .max_out     (cfg_max_out),
        .fifo_count  (fifo_count),
        .beat        (beat),
        .beat_last   (r_last),
        .ar_ready    (ar_ready),
        .req         (req),
        .ar_valid    (ar_valid)
    );

    dma_rd_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (beat),
        .push_data (push_word),
        .pop       (pop),
        .head_data (st_data),
        .not_empty (st_valid),
        .count     (fifo_count)
    );

    assign ar_id    = '0;
    assign ar_addr  = req.addr;
    assign ar_len   = req.len;
    assign ar_burst = req.kind;
    assign ar_size  = 3'b010;
    assign ar_prot  = 3'b000;
    assign st_last  = st_valid && (out_left == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            swap_q   <= 1'b0;
            out_left <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            done     <= 1'b0;
            swap_q   <= cmd_swap;
            out_left <= cmd_words;
        end else if (busy && pop) begin
            out_left <= out_left - LEN_W'(1);
            if (out_left == LEN_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_cnt   <= '0;
            timeout_err <= 1'b0;
        end else if (accept) begin
            stall_cnt   <= '0;
            timeout_err <= 1'b0;
        end else if (!busy || progress) begin
            stall_cnt <= '0;
        end else if (cfg_timeout != '0 && !timeout_err) begin
            if (stall_cnt == cfg_timeout - TO_W'(1))
                timeout_err <= 1'b1;
            else
                stall_cnt <= stall_cnt + TO_W'(1);
        end
    end

endmodule

// File: rtl/dma_rd_chan_chk.sv
module dma_rd_chan_chk
    import dma_rd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [31:0] ar_addr,
    input logic [3:0]  ar_len,
    input logic [1:0]  ar_burst,
    input logic        ar_valid,
    input logic        ar_ready,
    input logic        r_valid,
    input logic        r_ready,
    input logic        r_last,
    input logic [3:0]  cfg_max_out,
    input logic [31:0] st_data,
    input logic        st_valid,
    input logic        st_last,
    input logic        st_ready
);

    logic [3:0] open_bursts;

    always_ff @(posedge clk) begin
        if (rst)
            open_bursts <= '0;
        else
            open_bursts <= open_bursts + 4'(ar_valid && ar_ready)
                                       - 4'(r_valid && r_ready && r_last);
    end

    // R4: incrementing bursts stay inside one 4 KB page
    a_r4_page_edge: assert property (@(posedge clk) disable iff (rst)
        (ar_valid && ar_burst == 2'b01) |->
            (({1'b0, ar_addr[11:0]} + {7'd0, ar_len, 2'b00} + 13'd4) <= 13'd4096));

    // R11: request payload held until accepted
    a_r11_ar_hold: assert property (@(posedge clk) disable iff (rst)
        (ar_valid && !ar_ready) |=>
            (ar_valid && $stable(ar_addr) && $stable(ar_len) && $stable(ar_burst)));

    // R2: stream word held until accepted
    a_r2_st_hold: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));

    // R9: done only follows acceptance of the final word
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(st_valid && st_ready && st_last));

    // R9: busy and done never high together
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R6: in-flight burst cap respected at every accepted request
    a_r6_out_cap: assert property (@(posedge clk) disable iff (rst)
        (ar_valid && ar_ready) |-> (open_bursts < clamp_out(cfg_max_out)));

    // R1: no requests while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ar_valid);

endmodule

bind dma_rd_chan dma_rd_chan_chk u_chk (.*);

// File: tb/dma_rd_chan_bench.sv
module dma_rd_chan_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_start;
    logic [31:0] cmd_addr;
    logic [15:0] cmd_words;
    logic        cmd_fixed, cmd_swap;
    logic [3:0]  cfg_max_out;
    logic [15:0] cfg_timeout;
    logic        busy, done, timeout_err;
    logic [3:0]  ar_id;
    logic [31:0] ar_addr;
    logic [3:0]  ar_len;
    logic [2:0]  ar_size, ar_prot;
    logic [1:0]  ar_burst;
    logic        ar_valid, ar_ready;
    logic [31:0] r_data;
    logic        r_last, r_valid, r_ready;
    logic [31:0] st_data;
    logic        st_valid, st_last, st_ready;

    always #5 clk = ~clk;

    dma_rd_chan u_dma_rd_chan (.*);

    int total = 0;
    int bad   = 0;

    // transfer expectations
    logic [31:0] t_base;
    int          t_len;
    bit          t_fixed, t_swap;
    int          t_cap;
    int          idx;
    int          ar_words;
    int          first_len;
    logic [31:0] next_ar;

    // memory model state
    logic [31:0] qa [16];
    int          ql [16];
    bit          qf [16];
    int          qh, qt, qn, beat_i;
    int          delivered, popped, owed_beats;
    bit          hold_sink;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [31:0] rev_bytes(logic [31:0] w);
        logic [31:0] o;
        for (int b = 0; b < 4; b++)
            o[8*b +: 8] = w[8*(3-b) +: 8];
        return o;
    endfunction

    function automatic int eff_cap(logic [3:0] m);
        if (m == 0) return 1;
        if (m > 9) return 9;
        return int'(m);
    endfunction

    function automatic logic [31:0] exp_word(int i);
        logic [31:0] a, w;
        a = t_fixed ? t_base : t_base + 32'(4 * i);
        w = mem_word(a);
        return t_swap ? rev_bytes(w) : w;
    endfunction

    // observe handshakes that complete at the coming rising edge
    always @(negedge clk) begin
        if (!rst) begin
            if (ar_valid && ar_ready) begin
                int n;
                n = int'(ar_len) + 1;
                chk(ar_size == 3'b010 && n <= 16, "R4", "burst size/len", {ar_size, ar_len}, 64'h20);
                chk(ar_prot[1] == 1'b0 && ar_id == 0, "R7", "prot/id", {ar_prot, ar_id}, 0);
                chk(ar_burst == (t_fixed ? 2'b00 : 2'b01), "R3", "burst type", ar_burst, t_fixed ? 0 : 1);
                chk(ar_addr == (t_fixed ? t_base : next_ar), "R3", "burst address", ar_addr,
                    t_fixed ? t_base : next_ar);
                if (!t_fixed)
                    chk(int'(ar_addr[11:0]) + 4 * n <= 4096, "R4", "page crossing", ar_addr, n);
                chk((delivered - popped) + owed_beats + n <= 128, "R5", "buffer reservation",
                    (delivered - popped) + owed_beats + n, 128);
                chk(qn < t_cap, "R6", "in-flight cap", qn + 1, t_cap);
                if (ar_words == 0) first_len = n;
                qa[qt] = ar_addr; ql[qt] = n; qf[qt] = (ar_burst == 2'b00);
                qt = (qt + 1) % 16; qn++;
                owed_beats += n; ar_words += n;
                next_ar = ar_addr + 32'(4 * n);
            end
            if (r_valid && r_ready) begin
                delivered++; owed_beats--; beat_i++;
                if (beat_i == ql[qh]) begin
                    beat_i = 0; qh = (qh + 1) % 16; qn--;
                end
            end
            if (st_valid && st_ready) begin
                chk(st_data == exp_word(idx), t_swap ? "R8" : "R2", "stream word", st_data, exp_word(idx));
                chk(st_last == (idx == t_len - 1), "R2", "last flag", st_last, idx == t_len - 1);
                idx++; popped++;
            end
        end
    end

    // drive the memory side and the sink just after each rising edge
    always @(posedge clk) begin
        #1;
        ar_ready = ($urandom_range(0, 3) != 0);
        if (qn > 0 && $urandom_range(0, 2) != 0) begin
            r_valid = 1'b1;
            r_data  = mem_word(qf[qh] ? qa[qh] : qa[qh] + 32'(4 * beat_i));
            r_last  = (beat_i == ql[qh] - 1);
        end else begin
            r_valid = 1'b0;
            r_data  = '0;
            r_last  = 1'b0;
        end
        st_ready = hold_sink ? 1'b0 : ($urandom_range(0, 3) != 0);
    end

    task automatic start_cmd(logic [31:0] a, int len, bit fx, bit sw, logic [3:0] m, logic [15:0] tmo);
        t_base = a; t_len = len; t_fixed = fx; t_swap = sw; t_cap = eff_cap(m);
        idx = 0; ar_words = 0; first_len = 0; next_ar = a;
        @(posedge clk); #1;
        cmd_addr = a; cmd_words = 16'(len); cmd_fixed = fx; cmd_swap = sw;
        cfg_max_out = m; cfg_timeout = tmo; cmd_start = 1'b1;
        @(posedge clk); #1;
        cmd_start = 1'b0;
        @(negedge clk);
        chk(busy && !done && !timeout_err, "R1", "accept start", {busy, done, timeout_err}, 3'b100);
    endtask

    task automatic finish_cmd(bit exp_err);
        int guard = 0;
        while (idx < t_len && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 60000, "R2", "transfer completes", idx, t_len);
        @(negedge clk);
        chk(done && !busy, "R9", "done after last", {done, busy}, 2'b10);
        chk(ar_words == t_len, "R2", "words requested", ar_words, t_len);
        chk(timeout_err == exp_err, "R10", "timeout flag", timeout_err, exp_err);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        rst = 1'b1; cmd_start = 0; cmd_addr = 0; cmd_words = 0; cmd_fixed = 0; cmd_swap = 0;
        cfg_max_out = 4'd9; cfg_timeout = 0; ar_ready = 0; r_valid = 0; r_data = 0; r_last = 0;
        st_ready = 0; hold_sink = 0;
        qh = 0; qt = 0; qn = 0; beat_i = 0; delivered = 0; popped = 0; owed_beats = 0;
        t_base = 0; t_len = 0; t_fixed = 0; t_swap = 0; t_cap = 9; idx = 0;
        ar_words = 0; first_len = 0; next_ar = 0;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !timeout_err && !ar_valid && !st_valid, "R1", "reset idle",
            {busy, timeout_err, ar_valid, st_valid}, 0);
        chk(!done, "R9", "reset done low", done, 0);

        // R4: start two words below a page edge
        start_cmd(32'h0000_1FF8, 40, 0, 0, 4'd9, 16'd0);
        finish_cmd(0);
        chk(first_len == 2, "R4", "first burst cut at page", first_len, 2);

        // R3 + R8: keyhole with byte swap
        start_cmd(32'h0000_4444, 37, 1, 1, 4'd3, 16'd200);
        finish_cmd(0);

        // R1: start while busy is dropped
        start_cmd(32'h0001_0000, 60, 0, 0, 4'd2, 16'd0);
        repeat (20) @(posedge clk);
        #1; cmd_addr = 32'h00AB_0000; cmd_words = 16'd5; cmd_fixed = 1; cmd_start = 1'b1;
        @(posedge clk); #1; cmd_start = 1'b0;
        finish_cmd(0);

        // R1: zero-length start is dropped
        @(posedge clk); #1; cmd_words = 0; cmd_start = 1'b1;
        @(posedge clk); #1; cmd_start = 1'b0;
        repeat (5) @(negedge clk);
        chk(!busy && !ar_valid && done, "R1", "zero length ignored", {busy, ar_valid, done}, 3'b001);

        // R5 + R10: sink held off, buffer fills to exactly 128 and timer fires
        hold_sink = 1;
        start_cmd(32'h0000_2000, 300, 0, 0, 4'd0, 16'd40);
        repeat (800) @(negedge clk);
        chk(ar_words == 128, "R5", "requests stop at buffer size", ar_words, 128);
        chk(timeout_err && busy, "R10", "stall flagged", {timeout_err, busy}, 2'b11);
        hold_sink = 0;
        finish_cmd(1);

        // random mix
        for (int k = 0; k < 10; k++) begin
            logic [31:0] a;
            a = $urandom() & 32'h00FF_FFFC;
            start_cmd(a, $urandom_range(1, 200), $urandom_range(0, 1), $urandom_range(0, 1),
                      4'($urandom_range(0, 15)), 16'd300);
            finish_cmd(0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule